// File: doc/BRIEF.md
# Serial I/Q Sample Transmitter

This block takes pairs of 16-bit I and Q samples through a valid/ready handshake. It shifts them out serially with a framing strobe. Time is divided into bit slots. Each slot is one cycle in which the `bit_en` tick input is high. Two slots per data-clock period stand for double-data-rate output. The lanes and the strobe are registered, and they change only on slot ticks.

Six static-looking configuration inputs control the serial format. They choose:
- full 16-bit or cut 12-bit samples, and which end of the word a 12-bit sample keeps;
- least-significant or most-significant bit first;
- two lanes (I and Q in parallel) or one shared lane;
- which component leads on the shared lane;
- a single-slot strobe pulse or a strobe level that marks the first half of the frame.

The configuration is captured when a pair is accepted and holds for that whole frame. When a frame's final slot goes out, the next pair is taken in the same tick, so frames follow each other with no gap.

Top module: `iqs_serial_tx`

## Requirements
- R1: While `rst_n` is low, `lane_i`, `lane_q` and `strobe` are 0 and `s_ready` is 0, and the outputs clear as soon as `rst_n` falls.
- R2: `s_ready` is high only in a cycle with `bit_en` high while no frame is running or while the current frame shows its final slot; a pair taken in that cycle shows its first slot right after that edge.
- R3: `lane_i`, `lane_q` and `strobe` change only at clock edges where `bit_en` was high.
- R4: With `cfg_one_lane`=0 a frame lasts W slots (W = 12 when `cfg_narrow`=1, else 16) and slot k carries bit k of the I sample on `lane_i` and bit k of the Q sample on `lane_q`.
- R5: With `cfg_one_lane`=1 a frame lasts 2W slots on `lane_i`. The first W slots carry I when `cfg_q_first`=0 and carry Q when it is 1, and the other component follows. `lane_q` stays 0.
- R6: With `cfg_lsb_first`=1 slot k of a component carries sample bit k; with 0 it carries bit W-1-k.
- R7: With `cfg_narrow`=1 the sample is cut to 12 bits: bits 11..0 when `cfg_keep_low`=1, bits 15..4 when 0; with `cfg_narrow`=0 `cfg_keep_low` has no effect.
- R8: With `cfg_level_strobe`=0 the strobe is high in slot 0 of each frame only.
- R9: With `cfg_level_strobe`=1 the strobe is high for the first W/2 slots of a two-lane frame, or for the first W slots (the leading component) of a one-lane frame, and low for the rest.
- R10: When no frame is running the lanes and the strobe are 0.
- R11: Changing any configuration input while a frame runs does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-slot tick |
| cfg_narrow | input | 1 | 1: 12-bit samples, 0: 16-bit |
| cfg_keep_low | input | 1 | 12-bit cut keeps low bits (1) or high bits (0) |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_one_lane | input | 1 | 1: single shared lane |
| cfg_q_first | input | 1 | On the shared lane, Q leads when 1 |
| cfg_level_strobe | input | 1 | 1: half-frame level strobe, 0: one-slot pulse |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Pair accepted in this cycle when valid |
| s_i | input | 16 | I sample |
| s_q | input | 16 | Q sample |
| lane_i | output | 1 | I lane (shared lane in one-lane mode) |
| lane_q | output | 1 | Q lane |
| strobe | output | 1 | Framing strobe |

## Verification
The case that matters most is the end of one frame landing in the same tick as the start of the next. In that tick the final bit leaves, a new pair is taken, and the new configuration is captured. The bench provokes this by holding `s_valid` high with a second pair whose configuration differs from the first. It checks that `s_ready` rises in the final slot. It then checks that the very next slot shows slot 0 of the second frame, with the second frame's strobe and lane layout and no idle slot between. Other runs change the configuration inputs mid-frame and stretch slots over several cycles, so that capture and hold are judged apart from frame timing.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

  // Per-frame serial format, captured on acceptance.
  typedef struct packed {
    logic narrow;     // 12-bit samples
    logic keep_low;   // cut keeps low end
    logic lsb_first;  // bit order
    logic one_lane;   // shared lane
    logic q_first;    // leading component on shared lane
    logic level;      // half-frame strobe
  } iqs_cfg_t;

endpackage

// File: rtl/iqs_trim.sv
module iqs_trim #(
  parameter int SW = 16,
  parameter int NW = 12
) (
  input  logic [SW-1:0] raw,
  input  logic          narrow,
  input  logic          keep_low,
  output logic [SW-1:0] trimmed
);

  // Narrow samples are right-aligned so the bit selector indexes from 0.
  generate
    if (NW < SW) begin : g_cut
      localparam int PADW = SW - NW;
      always_comb begin
        if (!narrow)
          trimmed = raw;
        else if (keep_low)
          trimmed = {{PADW{1'b0}}, raw[NW-1:0]};
        else
          trimmed = {{PADW{1'b0}}, raw[SW-1 -: NW]};
      end
    end else begin : g_full
      logic unused_sel;
      assign unused_sel = narrow ^ keep_low;
      assign trimmed    = raw;
    end
  endgenerate

endmodule

// File: rtl/iqs_sample_hold.sv
module iqs_sample_hold #(
  parameter int SW = 16,
  parameter int NW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                narrow,
  input  logic                keep_low,
  input  logic [1:0][SW-1:0]  raw,      // [0]=I, [1]=Q
  output logic [1:0][SW-1:0]  nxt_samp
);

  logic [1:0][SW-1:0] trimmed;
  logic [1:0][SW-1:0] held;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_comp
      iqs_trim #(.SW(SW), .NW(NW)) u_trim (
        .raw      (raw[g]),
        .narrow   (narrow),
        .keep_low (keep_low),
        .trimmed  (trimmed[g])
      );

      always_comb begin
        nxt_samp[g] = load ? trimmed[g] : held[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held[g] <= '0;
        end else if (load) begin
          held[g] <= trimmed[g];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/iqs_frame_ctrl.sv
module iqs_frame_ctrl
  import iqs_pkg::*;
#(
  parameter int SW = 16,
  parameter int NW = 12,
  localparam int CW = $clog2(2*SW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          s_valid,
  input  iqs_cfg_t      cfg_in,
  output logic          s_ready,
  output logic          load,
  output logic          nxt_active,
  output logic [CW-1:0] nxt_cnt,
  output iqs_cfg_t      nxt_cfg,
  output logic          active,
  output iqs_cfg_t      cfg_act
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] comp_w;
  logic [CW-1:0] last;
  logic          frame_end;

  always_comb begin
    comp_w    = cfg_act.narrow ? CW'(NW) : CW'(SW);
    last      = cfg_act.one_lane ? ((comp_w << 1) - 1'b1) : (comp_w - 1'b1);
    frame_end = active && (cnt == last);
    // reset gates the handshake until the synchronised release
    s_ready   = rst_n && bit_en && (!active || frame_end);
    load      = s_ready && s_valid;
  end

  always_comb begin
    nxt_active = active;
    nxt_cnt    = cnt;
    nxt_cfg    = cfg_act;
    if (load) begin
      nxt_active = 1'b1;
      nxt_cnt    = '0;
      nxt_cfg    = cfg_in;
    end else if (s_ready) begin
      nxt_active = 1'b0;
      nxt_cnt    = '0;
    end else if (bit_en && active) begin
      nxt_cnt    = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      cfg_act <= '0;
    end else if (bit_en) begin
      active  <= nxt_active;
      cnt     <= nxt_cnt;
      cfg_act <= nxt_cfg;
    end
  end

endmodule

// File: rtl/iqs_bit_sel.sv
module iqs_bit_sel
  import iqs_pkg::*;
#(
  parameter int SW = 16,
  parameter int NW = 12,
  localparam int CW = $clog2(2*SW) + 1,
  localparam int IW = $clog2(SW)
) (
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  iqs_cfg_t      cfg,
  input  logic [SW-1:0] samp_i,
  input  logic [SW-1:0] samp_q,
  output logic          bit_i,
  output logic          bit_q,
  output logic          bit_strobe
);

  logic [CW-1:0] comp_w;
  logic [CW-1:0] half;
  logic [CW-1:0] k;
  logic          second;
  logic [SW-1:0] word;
  logic [IW-1:0] idx;

  always_comb begin
    comp_w = cfg.narrow ? CW'(NW) : CW'(SW);
    half   = cfg.one_lane ? comp_w : (comp_w >> 1);
    second = cfg.one_lane && (cnt >= comp_w);
    k      = second ? (cnt - comp_w) : cnt;
    word   = (second ^ cfg.q_first) ? samp_q : samp_i;
    idx    = cfg.lsb_first ? IW'(k) : IW'(comp_w - 1'b1 - k);

    bit_i      = active && (cfg.one_lane ? word[idx] : samp_i[idx]);
    bit_q      = active && !cfg.one_lane && samp_q[idx];
    bit_strobe = active && (cfg.level ? (cnt < half) : (cnt == '0));
  end

endmodule

// File: rtl/iqs_serial_tx.sv
module iqs_serial_tx
  import iqs_pkg::*;
#(
  parameter int SW = 16,
  parameter int NW = 12,
  localparam int CW = $clog2(2*SW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          cfg_narrow,
  input  logic          cfg_keep_low,
  input  logic          cfg_lsb_first,
  input  logic          cfg_one_lane,
  input  logic          cfg_q_first,
  input  logic          cfg_level_strobe,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [SW-1:0] s_i,
  input  logic [SW-1:0] s_q,
  output logic          lane_i,
  output logic          lane_q,
  output logic          strobe
);

  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  iqs_cfg_t           cfg_in;
  iqs_cfg_t           nxt_cfg;
  iqs_cfg_t           cfg_act;
  logic               load;
  logic               nxt_active;
  logic               frm_active;
  logic [CW-1:0]      nxt_cnt;
  logic [1:0][SW-1:0] nxt_samp;
  logic               bit_i;
  logic               bit_q;
  logic               bit_strobe;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign cfg_in = '{narrow:    cfg_narrow,
                    keep_low:  cfg_keep_low,
                    lsb_first: cfg_lsb_first,
                    one_lane:  cfg_one_lane,
                    q_first:   cfg_q_first,
                    level:     cfg_level_strobe};

  iqs_frame_ctrl #(.SW(SW), .NW(NW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bit_en     (bit_en),
    .s_valid    (s_valid),
    .cfg_in     (cfg_in),
    .s_ready    (s_ready),
    .load       (load),
    .nxt_active (nxt_active),
    .nxt_cnt    (nxt_cnt),
    .nxt_cfg    (nxt_cfg),
    .active     (frm_active),
    .cfg_act    (cfg_act)
  );

  iqs_sample_hold #(.SW(SW), .NW(NW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .narrow   (cfg_narrow),
    .keep_low (cfg_keep_low),
    .raw      ({s_q, s_i}),
    .nxt_samp (nxt_samp)
  );

  // The selector looks at next state so the output flops hold the
  // bit of the slot that starts at the same edge.
  iqs_bit_sel #(.SW(SW), .NW(NW)) u_sel (
    .active     (nxt_active),
    .cnt        (nxt_cnt),
    .cfg        (nxt_cfg),
    .samp_i     (nxt_samp[0]),
    .samp_q     (nxt_samp[1]),
    .bit_i      (bit_i),
    .bit_q      (bit_q),
    .bit_strobe (bit_strobe)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lane_i <= 1'b0;
      lane_q <= 1'b0;
      strobe <= 1'b0;
    end else if (bit_en) begin
      lane_i <= bit_i;
      lane_q <= bit_q;
      strobe <= bit_strobe;
    end
  end

endmodule

// File: rtl/iqs_serial_tx_chk.sv
module iqs_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic s_valid,
  input logic s_ready,
  input logic lane_i,
  input logic lane_q,
  input logic strobe,
  input logic frm_active,
  input logic act_one_lane,
  input logic act_level
);

  a_r2_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_en);

  a_r3_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({lane_i, lane_q, strobe}));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_active |-> !(lane_i || lane_q || strobe));

  a_r5_shared_q_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_active && act_one_lane) |-> !lane_q);

  a_r8_strobe_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> strobe);

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && bit_en && !act_level) |=> (!strobe || $past(s_valid && s_ready)));

endmodule

bind iqs_serial_tx iqs_serial_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_en       (bit_en),
  .s_valid      (s_valid),
  .s_ready      (s_ready),
  .lane_i       (lane_i),
  .lane_q       (lane_q),
  .strobe       (strobe),
  .frm_active   (frm_active),
  .act_one_lane (cfg_act.one_lane),
  .act_level    (cfg_act.level)
);

// File: tb/iqs_serial_tx_test.sv
`timescale 1ns/1ps
module iqs_serial_tx_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        cfg_narrow, cfg_keep_low, cfg_lsb_first;
  logic        cfg_one_lane, cfg_q_first, cfg_level_strobe;
  logic        s_valid;
  logic        s_ready;
  logic [15:0] s_i, s_q;
  logic        lane_i, lane_q, strobe;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  iqs_serial_tx uut (
    .clk (clk), .rst_n (rst_n), .bit_en (bit_en),
    .cfg_narrow (cfg_narrow), .cfg_keep_low (cfg_keep_low),
    .cfg_lsb_first (cfg_lsb_first), .cfg_one_lane (cfg_one_lane),
    .cfg_q_first (cfg_q_first), .cfg_level_strobe (cfg_level_strobe),
    .s_valid (s_valid), .s_ready (s_ready), .s_i (s_i), .s_q (s_q),
    .lane_i (lane_i), .lane_q (lane_q), .strobe (strobe)
  );

  // {div[1:0], cfg[5:0], I, Q}; cfg = {narrow, keep_low, lsb_first, one_lane, q_first, level}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {2'd1, 6'b000000, 16'hA5C3, 16'h3C96},  // R4 two-lane 16-bit, R6 msb first, R8 pulse
    {2'd1, 6'b000001, 16'h8001, 16'h7FFE},  // R9 level, two-lane
    {2'd1, 6'b001000, 16'h1234, 16'hABCD},  // R6 lsb first
    {2'd1, 6'b100000, 16'hF0F5, 16'h0A1B},  // R7 upper 12 kept
    {2'd1, 6'b110000, 16'hF0F5, 16'h0A1B},  // R7 lower 12 kept
    {2'd1, 6'b100001, 16'hFFF0, 16'h000F},  // R7 + R9: 6 slots high
    {2'd1, 6'b000100, 16'h9ABC, 16'h1357},  // R5 shared lane, I leads
    {2'd1, 6'b000111, 16'h9ABC, 16'h1357},  // R5 Q leads, R9 level over whole lead
    {2'd2, 6'b111101, 16'hC35A, 16'h5AC3},  // R3 stretched slots, narrow shared lane
    {2'd3, 6'b101010, 16'h6DB6, 16'h0000}   // R3, q_first ignored on two lanes
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [5:0] c);
    {cfg_narrow, cfg_keep_low, cfg_lsb_first, cfg_one_lane, cfg_q_first, cfg_level_strobe} = c;
  endtask

  function automatic int frame_len(input logic [5:0] c);
    return (c[5] ? 12 : 16) * (c[2] ? 2 : 1);
  endfunction

  // expected {strobe, lane_i, lane_q} for a slot, from the requirements
  function automatic logic [2:0] exp_out(input logic [5:0] c, input logic [15:0] i,
                                         input logic [15:0] q, input int slot);
    int w, k, half, pos;
    logic [15:0] ti, tq, word;
    logic li, lq, st;
    w  = c[5] ? 12 : 16;
    ti = c[5] ? (c[4] ? {4'h0, i[11:0]} : {4'h0, i[15:4]}) : i;
    tq = c[5] ? (c[4] ? {4'h0, q[11:0]} : {4'h0, q[15:4]}) : q;
    if (c[2]) begin
      word = ((slot >= w) != c[1]) ? tq : ti;
      k    = slot % w;
      half = w;
    end else begin
      word = ti;
      k    = slot;
      half = w / 2;
    end
    pos = c[3] ? k : (w - 1 - k);
    li  = word[pos];
    lq  = c[2] ? 1'b0 : tq[pos];
    st  = c[0] ? (slot < half) : (slot == 0);
    return {st, li, lq};
  endfunction

  // Entered at the negedge showing slot 0, with bit_en high.
  task automatic play(input logic [5:0] c, input logic [15:0] i, input logic [15:0] q,
                      input int div);
    int len;
    logic [2:0] e;
    len = frame_len(c);
    for (int s = 0; s < len; s++) begin
      e = exp_out(c, i, q, s);
      check(c[2] ? "R5 lanes" : "R4 lanes", {30'd0, lane_i, lane_q}, {30'd0, e[1:0]});
      check(c[0] ? "R9 strobe" : "R8 strobe", {31'd0, strobe}, {31'd0, e[2]});
      #1 check("R2 ready", {31'd0, s_ready}, {31'd0, s == len - 1});
      for (int d = 1; d < div; d++) begin
        bit_en = 1'b0;
        @(negedge clk);
        check("R3 hold", {29'd0, strobe, lane_i, lane_q}, {29'd0, e});
        #1 check("R2 no tick", {31'd0, s_ready}, 32'd0);
      end
      bit_en = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic [5:0] c, input logic [15:0] i, input logic [15:0] q,
                           input int div);
    @(negedge clk);
    set_cfg(c);
    s_i = i; s_q = q; s_valid = 1'b1; bit_en = 1'b1;
    #1 check("R2 idle ready", {31'd0, s_ready}, 32'd1);
    @(negedge clk);
    s_valid = 1'b0;
    set_cfg(~c);  // R11: mid-frame change must not matter
    s_i = ~i; s_q = ~q;
    play(c, i, q, div);
    check("R10 idle", {29'd0, strobe, lane_i, lane_q}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b1; s_valid = 1'b0; s_i = '0; s_q = '0;
    set_cfg(6'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", {29'd0, strobe, lane_i, lane_q}, 32'd0);
    check("R1 ready", {31'd0, s_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 idle after reset", {29'd0, strobe, lane_i, lane_q}, 32'd0);

    for (int n = 0; n < NV; n++)
      run_frame(VEC[n][37:32], VEC[n][31:16], VEC[n][15:0], int'(VEC[n][39:38]));

    // R2: back-to-back frames, second with a different format
    @(negedge clk);
    set_cfg(6'b100000); s_i = 16'hBEEF; s_q = 16'h1234; s_valid = 1'b1; bit_en = 1'b1;
    @(negedge clk);
    set_cfg(6'b000101); s_i = 16'hC001; s_q = 16'h0FF0;  // valid stays high
    play(6'b100000, 16'hBEEF, 16'h1234, 1);
    s_valid = 1'b0;
    play(6'b000101, 16'hC001, 16'h0FF0, 1);
    check("R10 idle after pair", {29'd0, strobe, lane_i, lane_q}, 32'd0);

    // R3: no ticks while idle with valid held: nothing accepted
    bit_en = 1'b0; s_valid = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 idle no tick", {30'd0, s_ready, strobe}, 32'd0);
    s_valid = 1'b0; bit_en = 1'b1;

    // R1: reset mid-frame clears outputs at once
    @(negedge clk);
    set_cfg(6'b000001); s_i = 16'hFFFF; s_q = 16'hFFFF; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 frame running", {31'd0, strobe}, 32'd1);
    rst_n = 1'b0;
    #1 check("R1 async clear", {29'd0, strobe, lane_i, lane_q}, 32'd0);
    check("R1 ready in reset", {31'd0, s_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 idle after reset", {29'd0, strobe, lane_i, lane_q}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule